// File: doc/BRIEF.md
# Analog Acquisition Scan Sequencer

This block sequences a multiplexed analog-to-digital acquisition path. Software writes a channel-and-gain register, a last-channel register and a command register, and the block drives the multiplexer select and a 2-bit gain code toward the analog front end. It pulses a start strobe to an external converter and holds itself busy until the converter returns a done pulse with its 12-bit result, which it latches.

A conversion can be launched by a software command, by an external trigger pulse that passes a minimum-width filter, or by an internal pacer. The pacer's period is a base interval multiplied by a power of two, selectable over eleven settings. Three acquisition modes decide which sources count and how the channel moves. In random mode only software starts count. In repetitive mode every accepted trigger converts the same channel. In scan mode the channel steps forward after each conversion and wraps at the last channel.

Completion raises sticky end-of-conversion and end-of-scan flags. A trigger refused for being early raises an overrun flag. Two interrupt outputs can each be routed to the pacer, end-of-conversion or end-of-scan flag. A write to the clear location drops all of these flags.

Top module: `acq_scan_seq`

## Requirements
- R1: A write with `wrSel`=0 loads the channel from `wrData[4:0]` and the gain code from `wrData[6:5]`; both appear on `muxSel` and `gainCode` the cycle after the write edge. A write with `wrSel`=1 loads the last channel from `wrData[4:0]`.
- R2: A write with `wrSel`=2 and `wrData[2]`=1 (go) produces exactly one `convStart` pulse the cycle after the write edge if idle. `statusOut[0]` (busy) stays high until the edge that samples `convDone`.
- R3: The edge that samples `convDone` while busy latches `convData` into `resultOut`. With `offsetBin`=1 the result's bit 11 is shown inverted (offset binary); otherwise it is straight binary.
- R4: The mode is `wrData[1:0]` of a command write: 0 random, 1 repetitive, 2 scan. In random mode (and code 3) external and pacer triggers start nothing; only go does.
- R5: In repetitive mode each accepted trigger converts the channel last loaded through R1, unchanged.
- R6: In scan mode each completed conversion advances the channel by one. When the completed channel equals the last channel, `eosOut`/`statusOut[2]` is set and the channel reloads the starting channel from R1.
- R7: With `wrData[3]` (external enable) set in a non-random mode, the external trigger is synchronised and accepted only after it has been sampled high on 4 consecutive edges. Each pulse starts at most one conversion, however long it lasts.
- R8: With `wrData[4]` (pacer enable) set, the pacer fires every 4·2^(10−n) cycles, where n = `pacerSel` (values above 10 act as 10). In a non-random mode each firing starts a conversion, and the first firing comes that many cycles after the enabling write.
- R9: A trigger accepted while busy starts nothing and sets the overrun flag `statusOut[3]`.
- R10: `intA`/`intB` follow the pending flag chosen by `srcSelA`/`srcSelB`: 0 none, 1 pacer, 2 end-of-conversion, 3 end-of-scan. A write with `wrSel`=3 clears the pacer, end-of-conversion, end-of-scan and overrun flags.
- R11: Active-low `rstN` clears all registers and flags, stops any conversion and returns `muxSel` and `resultOut` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Write target: 0 channel/gain, 1 last channel, 2 command, 3 clear flags |
| wrData | input | 7 | Write data |
| extTrig | input | 1 | External trigger, asynchronous |
| pacerSel | input | 4 | Pacer interval exponent n |
| srcSelA | input | 2 | Interrupt A source select |
| srcSelB | input | 2 | Interrupt B source select |
| offsetBin | input | 1 | Present the result as offset binary |
| convDone | input | 1 | Converter finished pulse |
| convData | input | 12 | Converter result |
| muxSel | output | 5 | Multiplexer channel select |
| gainCode | output | 2 | Amplifier gain code (x1, x2, x4, x8) |
| convStart | output | 1 | Converter start pulse |
| resultOut | output | 12 | Latched result |
| statusOut | output | 4 | {overrun, end-of-scan, end-of-conversion, busy} |
| eocOut | output | 1 | End-of-conversion flag |
| eosOut | output | 1 | End-of-scan flag |
| intA | output | 1 | Interrupt A |
| intB | output | 1 | Interrupt B |

## Verification
Register loads and the go strobe are due one cycle after the write edge. An external pulse costs two synchroniser stages plus the four-sample width count before its start strobe. The result and the flags change on the edge that samples `convDone`. The bench drives every input on the falling edge and reads outputs on the following falling edge. A converter model answers each start three cycles later and logs the cycle number and channel, so pacer intervals and scan order are checked as exact cycle gaps and sequences, not by polling.

// File: rtl/acq_pkg.sv
package acq_pkg;
  localparam logic [1:0] SEL_CHAN = 2'd0;
  localparam logic [1:0] SEL_LAST = 2'd1;
  localparam logic [1:0] SEL_CMD  = 2'd2;
  localparam logic [1:0] SEL_CLR  = 2'd3;

  localparam logic [1:0] MODE_RANDOM = 2'd0;
  localparam logic [1:0] MODE_REPEAT = 2'd1;
  localparam logic [1:0] MODE_SCAN   = 2'd2;

  localparam logic [1:0] SRC_NONE  = 2'd0;
  localparam logic [1:0] SRC_PACER = 2'd1;
  localparam logic [1:0] SRC_EOC   = 2'd2;
  localparam logic [1:0] SRC_EOS   = 2'd3;

  typedef struct packed {
    logic loadChan;
    logic loadLast;
    logic capture;
    logic advance;
  } dpStrobe_t;
endpackage

// File: rtl/acq_ctrl.sv
module acq_ctrl import acq_pkg::*; #(
  parameter int PACER_BASE  = 4,
  parameter int PACER_STEPS = 10,
  parameter int EXT_MIN     = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] wrSel,
  input  logic [4:0] cmdBits,
  input  logic       extTrig,
  input  logic [3:0] pacerSel,
  input  logic [1:0] srcSelA,
  input  logic [1:0] srcSelB,
  input  logic       convDone,
  input  logic       atLast,
  output dpStrobe_t  st,
  output logic       convStart,
  output logic       busy,
  output logic       eocFlag,
  output logic       eosFlag,
  output logic       overrun,
  output logic       intA,
  output logic       intB
);
  localparam int PACER_MAX = PACER_BASE << PACER_STEPS;
  localparam int PC_W      = $clog2(PACER_MAX + 1);
  localparam int EC_W      = $clog2(EXT_MIN + 1);

  logic [1:0]      mode;
  logic            extEn, pacerEn, pacerPend;
  logic            wrCmd, wrClr, swGo, modeTrig, trigger, capture;
  logic [3:0]      shiftAmt;
  logic [PC_W-1:0] period, pacerCnt;
  logic            pacerTick;
  logic [1:0]      extSync;
  logic [EC_W-1:0] extCnt;
  logic            extAccept;

  assign wrCmd    = wrEn && (wrSel == SEL_CMD);
  assign wrClr    = wrEn && (wrSel == SEL_CLR);
  assign swGo     = wrCmd && cmdBits[2];
  assign modeTrig = (mode == MODE_REPEAT) || (mode == MODE_SCAN);
  assign capture  = convDone && busy;

  // pacer: terminal count is the base interval shifted by the selected exponent
  always_comb begin
    shiftAmt = (pacerSel > 4'(PACER_STEPS)) ? 4'd0 : (4'(PACER_STEPS) - pacerSel);
    period   = PC_W'(PACER_BASE) << shiftAmt;
  end
  assign pacerTick = pacerEn && (pacerCnt >= period - PC_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 pacerCnt <= '0;
    else if (!pacerEn || pacerTick) pacerCnt <= '0;
    else                       pacerCnt <= pacerCnt + PC_W'(1);
  end

  // external trigger: two-flop synchroniser, then a saturating high-time count
  assign extAccept = extSync[1] && (extCnt == EC_W'(EXT_MIN - 1));
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extSync <= '0;
      extCnt  <= '0;
    end else begin
      extSync <= {extSync[0], extTrig};
      if (!extSync[1])                  extCnt <= '0;
      else if (extCnt != EC_W'(EXT_MIN)) extCnt <= extCnt + EC_W'(1);
    end
  end

  assign trigger = swGo || (modeTrig && ((extEn && extAccept) || pacerTick));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode <= MODE_RANDOM; extEn <= 1'b0; pacerEn <= 1'b0;
      convStart <= 1'b0; busy <= 1'b0; overrun <= 1'b0;
      eocFlag <= 1'b0; eosFlag <= 1'b0; pacerPend <= 1'b0;
    end else begin
      if (wrCmd) begin
        mode    <= cmdBits[1:0];
        extEn   <= cmdBits[3];
        pacerEn <= cmdBits[4];
      end
      convStart <= trigger && !busy;
      if (trigger && !busy) busy <= 1'b1;
      else if (capture)     busy <= 1'b0;
      if (trigger && busy)  overrun <= 1'b1;
      else if (wrClr)       overrun <= 1'b0;
      if (capture)          eocFlag <= 1'b1;
      else if (wrClr)       eocFlag <= 1'b0;
      if (capture && mode == MODE_SCAN && atLast) eosFlag <= 1'b1;
      else if (wrClr)       eosFlag <= 1'b0;
      if (pacerTick)        pacerPend <= 1'b1;
      else if (wrClr)       pacerPend <= 1'b0;
    end
  end

  function automatic logic pick(input logic [1:0] src, input logic p, input logic c, input logic s);
    case (src)
      SRC_PACER: pick = p;
      SRC_EOC:   pick = c;
      SRC_EOS:   pick = s;
      default:   pick = 1'b0;
    endcase
  endfunction

  assign intA = pick(srcSelA, pacerPend, eocFlag, eosFlag);
  assign intB = pick(srcSelB, pacerPend, eocFlag, eosFlag);

  assign st.loadChan = wrEn && (wrSel == SEL_CHAN);
  assign st.loadLast = wrEn && (wrSel == SEL_LAST);
  assign st.capture  = capture;
  assign st.advance  = capture && (mode == MODE_SCAN);

  a_r2_single_start: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);
  a_r2_busy_until_done: assert property (@(posedge clk) disable iff (!rstN)
    busy && !convDone |=> busy);
  a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overrun && !wrClr |=> overrun);
  a_r10_clear_eoc: assert property (@(posedge clk) disable iff (!rstN)
    wrClr && !(convDone && busy) |=> !eocFlag);
  a_r7_ext_one_shot: assert property (@(posedge clk) disable iff (!rstN)
    extAccept |=> !extAccept);
endmodule

// File: rtl/acq_datapath.sv
module acq_datapath import acq_pkg::*; #(
  parameter int CH_W  = 5,
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        st,
  input  logic [CH_W+1:0]  wrData,
  input  logic [RES_W-1:0] convData,
  input  logic             offsetBin,
  output logic [CH_W-1:0]  muxSel,
  output logic [1:0]       gainCode,
  output logic             atLast,
  output logic [RES_W-1:0] resultOut
);
  logic [CH_W-1:0]  startChan, lastChan, curChan;
  logic [1:0]       gainReg;
  logic [RES_W-1:0] resultReg;

  assign atLast = (curChan == lastChan);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startChan <= '0; lastChan <= '0; curChan <= '0;
      gainReg <= '0; resultReg <= '0;
    end else begin
      if (st.loadChan) begin
        startChan <= wrData[CH_W-1:0];
        curChan   <= wrData[CH_W-1:0];
        gainReg   <= wrData[CH_W+1:CH_W];
      end else if (st.advance) begin
        curChan <= atLast ? startChan : curChan + CH_W'(1);
      end
      if (st.loadLast) lastChan  <= wrData[CH_W-1:0];
      if (st.capture)  resultReg <= convData;
    end
  end

  assign muxSel    = curChan;
  assign gainCode  = gainReg;
  assign resultOut = resultReg ^ {offsetBin, {(RES_W-1){1'b0}}};

  a_r6_wrap_to_start: assert property (@(posedge clk) disable iff (!rstN)
    st.advance && atLast && !st.loadChan |=> muxSel == $past(startChan));
  a_r6_step_up: assert property (@(posedge clk) disable iff (!rstN)
    st.advance && !atLast && !st.loadChan |=> muxSel == $past(curChan) + CH_W'(1));
endmodule

// File: rtl/acq_scan_seq.sv
module acq_scan_seq import acq_pkg::*; #(
  parameter int CH_W        = 5,
  parameter int RES_W       = 12,
  parameter int PACER_BASE  = 4,
  parameter int PACER_STEPS = 10,
  parameter int EXT_MIN     = 4,
  localparam int WR_W       = CH_W + 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrSel,
  input  logic [WR_W-1:0]  wrData,
  input  logic             extTrig,
  input  logic [3:0]       pacerSel,
  input  logic [1:0]       srcSelA,
  input  logic [1:0]       srcSelB,
  input  logic             offsetBin,
  input  logic             convDone,
  input  logic [RES_W-1:0] convData,
  output logic [CH_W-1:0]  muxSel,
  output logic [1:0]       gainCode,
  output logic             convStart,
  output logic [RES_W-1:0] resultOut,
  output logic [3:0]       statusOut,
  output logic             eocOut,
  output logic             eosOut,
  output logic             intA,
  output logic             intB
);
  dpStrobe_t st;
  logic busy, eocFlag, eosFlag, overrun, atLast;

  acq_ctrl #(.PACER_BASE(PACER_BASE), .PACER_STEPS(PACER_STEPS), .EXT_MIN(EXT_MIN)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .cmdBits(wrData[4:0]),
    .extTrig(extTrig), .pacerSel(pacerSel), .srcSelA(srcSelA), .srcSelB(srcSelB),
    .convDone(convDone), .atLast(atLast), .st(st), .convStart(convStart), .busy(busy),
    .eocFlag(eocFlag), .eosFlag(eosFlag), .overrun(overrun), .intA(intA), .intB(intB));

  acq_datapath #(.CH_W(CH_W), .RES_W(RES_W)) uDp (
    .clk(clk), .rstN(rstN), .st(st), .wrData(wrData), .convData(convData),
    .offsetBin(offsetBin), .muxSel(muxSel), .gainCode(gainCode), .atLast(atLast),
    .resultOut(resultOut));

  assign statusOut = {overrun, eosFlag, eocFlag, busy};
  assign eocOut    = eocFlag;
  assign eosOut    = eosFlag;
endmodule

// File: tb/acq_scan_seq_test.sv
module acq_scan_seq_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN = 1'b0, wrEn = 1'b0, extTrig = 1'b0, offsetBin = 1'b0, convDone = 1'b0;
  logic [1:0] wrSel = '0, srcSelA = 2'd2, srcSelB = 2'd3;
  logic [6:0] wrData = '0;
  logic [3:0] pacerSel = 4'd10;
  logic [11:0] convData = '0;
  logic [4:0] muxSel;
  logic [1:0] gainCode;
  logic convStart, eocOut, eosOut, intA, intB;
  logic [11:0] resultOut;
  logic [3:0] statusOut;

  acq_scan_seq uut (.*);

  int errors = 0, checks = 0, cyc = 0, logCount = 0, latCnt = 0;
  logic [4:0] chanLog [0:63];
  int startCyc [0:63];

  always @(posedge clk) cyc++;

  // converter model: answers each start three cycles later
  always @(negedge clk) begin
    convDone = 1'b0;
    if (convStart) begin
      if (logCount < 64) begin chanLog[logCount] = muxSel; startCyc[logCount] = cyc; end
      logCount++;
      latCnt = 3;
    end else if (latCnt != 0) begin
      latCnt--;
      if (latCnt == 0) begin convDone = 1'b1; convData = {gainCode, 5'b0, muxSel}; end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] s, input logic [6:0] d);
    @(negedge clk); wrEn = 1'b1; wrSel = s; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 40; i++) begin
      if (!statusOut[0]) break;
      @(negedge clk);
    end
  endtask

  task automatic pulseExt(input int w);
    @(negedge clk); extTrig = 1'b1;
    repeat (w) @(negedge clk);
    extTrig = 1'b0;
    repeat (14) @(negedge clk);
  endtask

  task automatic testReset();
    check("R11 reset status", statusOut, 0);
    check("R11 reset result", resultOut, 0);
    check("R11 reset muxSel", muxSel, 0);
    check("R11 reset ints", {intA, intB, convStart}, 0);
  endtask

  task automatic testChanGain();
    writeReg(2'd0, 7'h69);
    check("R1 muxSel", muxSel, 9);
    check("R1 gainCode", gainCode, 3);
  endtask

  task automatic testSoftStart();
    int n0;
    writeReg(2'd0, 7'h43);
    n0 = logCount;
    writeReg(2'd2, 7'h04);
    check("R2 start pulse", convStart, 1);
    check("R2 busy", statusOut[0], 1);
    waitIdle();
    check("R2 one conversion", logCount - n0, 1);
    check("R3 straight result", resultOut, 12'h803);
    check("R3 eoc", eocOut, 1);
    @(negedge clk); offsetBin = 1'b1;
    #1 check("R3 offset binary", resultOut, 12'h003);
    offsetBin = 1'b0;
    check("R10 intA eoc", intA, 1);
    check("R10 intB eos idle", intB, 0);
    writeReg(2'd3, 7'h00);
    check("R10 clear", {intA, eocOut}, 0);
  endtask

  task automatic testOverrun();
    int n0 = logCount;
    writeReg(2'd2, 7'h04);
    writeReg(2'd2, 7'h04);
    waitIdle();
    check("R9 no extra start", logCount - n0, 1);
    check("R9 overrun", statusOut[3], 1);
    writeReg(2'd3, 7'h00);
    check("R9 R10 overrun cleared", statusOut[3], 0);
  endtask

  task automatic testScan();
    int n0;
    writeReg(2'd0, 7'h03);
    writeReg(2'd1, 7'h05);
    n0 = logCount;
    for (int k = 0; k < 4; k++) begin
      writeReg(2'd2, 7'h06);
      waitIdle();
      check("R6 scan channel", chanLog[n0 + k], (k == 3) ? 3 : 3 + k);
      check("R6 eos", eosOut, (k == 2) ? 1 : 0);
      if (k == 2) begin
        check("R6 reload", muxSel, 3);
        check("R10 intB eos", intB, 1);
      end
      writeReg(2'd3, 7'h00);
    end
  endtask

  task automatic testExt();
    int n0;
    writeReg(2'd2, 7'h09);
    n0 = logCount; pulseExt(3);
    check("R7 short pulse rejected", logCount - n0, 0);
    n0 = logCount; pulseExt(4);
    check("R7 min pulse accepted", logCount - n0, 1);
    check("R5 same channel", chanLog[n0], muxSel);
    n0 = logCount; pulseExt(15);
    check("R7 long pulse once", logCount - n0, 1);
    writeReg(2'd2, 7'h08);
    n0 = logCount; pulseExt(6);
    check("R4 random ignores ext", logCount - n0, 0);
    writeReg(2'd3, 7'h00);
  endtask

  task automatic testPacer();
    int n0;
    srcSelA = 2'd1; pacerSel = 4'd9;
    writeReg(2'd0, 7'h2A);
    n0 = logCount;
    writeReg(2'd2, 7'h11);
    for (int i = 0; i < 100; i++) begin
      if (logCount - n0 >= 3) break;
      @(negedge clk);
    end
    writeReg(2'd2, 7'h01);
    waitIdle();
    check("R8 first gap", startCyc[n0 + 1] - startCyc[n0], 8);
    check("R8 second gap", startCyc[n0 + 2] - startCyc[n0 + 1], 8);
    check("R5 repeat channel", chanLog[n0 + 2], 10);
    check("R10 intA pacer", intA, 1);
    writeReg(2'd3, 7'h00);
    pacerSel = 4'd15;
    n0 = logCount;
    writeReg(2'd2, 7'h10);
    repeat (40) @(negedge clk);
    check("R4 random ignores pacer", logCount - n0, 0);
    check("R8 pacer still ticks", intA, 1);
    writeReg(2'd2, 7'h00);
    srcSelA = 2'd2;
  endtask

  task automatic testResetMid();
    writeReg(2'd2, 7'h04);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    check("R11 mid reset status", statusOut, 0);
    check("R11 mid reset muxSel", muxSel, 0);
    check("R11 mid reset result", resultOut, 0);
    rstN = 1'b1;
    repeat (6) @(negedge clk);
    check("R11 stays idle", statusOut, 0);
  endtask

  initial begin
    #(4 * 200000);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testChanGain();
    testSoftStart();
    testOverrun();
    testScan();
    testExt();
    testPacer();
    testResetMid();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule